// File: doc/BRIEF.md
# 64-bit Virtual Address Segment Classifier

This block sorts every 64-bit virtual address issued by a load, store or instruction fetch into one of three outcomes before any translation-buffer lookup starts: the address must be translated by the translation buffer, the address maps straight to a physical address, or the address is illegal. The decision depends on the address, on whether the request comes from user mode, and on four status enables: one for the extended user region, one for the extended supervisor region, one for the extended kernel regions, and an error-level flag.

Both address layouts are covered. The first is the sign-extended 32-bit layout, with a low user segment and kernel segments at the top of the space. The second is the extended 64-bit layout, with user, supervisor, kernel physical-window and kernel mapped regions. The checks run as a strict priority chain, and the first range that matches decides the result. The segment size is 40 bits and the physical size is 36 bits, and the limits of the extended regions are derived from these two values. The result is registered and appears one cycle after the request, together with a one-cycle valid pulse.

Top module: `vas_classify`

## Requirements
- R1: After reset, and until the first request, `rsp_vld` is 0, `rsp_code` is 00, `rsp_pa` is 0 and `rsp_perm` is 0.
- R2: A request sampled with `req_vld`=1 on a rising edge produces its result on that same edge, with `rsp_vld`=1 for exactly that cycle. Back-to-back requests give back-to-back results. While `req_vld`=0, `rsp_vld` is 0 and `rsp_code`, `rsp_pa` and `rsp_perm` keep their last values.
- R3: With `req_user`=1, any address above 0x3FFF_FFFF_FFFF_FFFF gives bad-address (code 10), ahead of every other check.
- R4: Addresses 0 through 0x7FFF_FFFF give needs-lookup (code 00), except when `st_erl`=1 and `req_user`=1 together. In that case the result is direct (code 01) with `rsp_pa` equal to the address.
- R5: Addresses from 0x8000_0000 up to 0x3FFF_FFFF_FFFF_FFFE give needs-lookup when `st_ux`=1 and the address is below 0x0000_00FF_FFFF_FFFF. Every other address in this range gives bad-address.
- R6: Addresses from 0x3FFF_FFFF_FFFF_FFFF up to 0x7FFF_FFFF_FFFF_FFFE give needs-lookup when `st_sx`=1 and the address is below 0x4000_00FF_FFFF_FFFF. Every other address in this range gives bad-address.
- R7: For addresses from 0x7FFF_FFFF_FFFF_FFFF up to 0xBFFF_FFFF_FFFF_FFFE, the result is direct when `st_kx`=1 and (address AND 0x03FF_FFFF_FFFF_FFFF) is below 0x0000_000F_FFFF_FFFF. In that case `rsp_pa` = address AND 0x0000_00FF_FFFF_FFFF. Every other address in this range gives bad-address.
- R8: Addresses from 0xBFFF_FFFF_FFFF_FFFF up to 0xFFFF_FFFF_7FFF_FFFE give needs-lookup when `st_kx`=1 and the address is below 0xC000_00FF_7FFF_FFFF. Every other address in this range gives bad-address.
- R9: Each remaining address, from 0xFFFF_FFFF_7FFF_FFFF upward, is handled by its sign-extended kernel segment. Below 0xFFFF_FFFF_C000_0000 the result is direct with `rsp_pa` = address AND 0xFFFF_FFFF. Here the boundary at 0xFFFF_FFFF_A000_0000 separates two unmapped segments that behave alike. From 0xFFFF_FFFF_C000_0000 upward the result is needs-lookup. None of these segments depends on any enable.
- R10: `rsp_perm` bit 0 is read and bit 1 is write. A direct result carries `rsp_perm`=11. Needs-lookup and bad-address results carry `rsp_perm`=00 and `rsp_pa`=0. Code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address to classify |
| req_user | input | 1 | Request issued in user mode |
| st_ux | input | 1 | Extended user region enable |
| st_sx | input | 1 | Extended supervisor region enable |
| st_kx | input | 1 | Extended kernel regions enable |
| st_erl | input | 1 | Error-level flag |
| rsp_vld | output | 1 | Result valid pulse |
| rsp_code | output | 2 | 00 needs-lookup, 01 direct, 10 bad-address |
| rsp_pa | output | 64 | Physical address for direct results, else 0 |
| rsp_perm | output | 2 | Bit 0 read, bit 1 write |

## Verification
Each range boundary is probed with the last address inside the range and the first address beyond it. This shows whether a comparison is strict or inclusive, and whether the priority order is right at the places where two ranges touch. Those addresses are repeated for all 32 combinations of the user flag and the four enables, so an enable that gates the wrong region, or a user check placed in the wrong order, shows up as a wrong code. Physical-window addresses with nonzero cache-attribute bits, and kernel addresses with set upper bits, check that the masking drops exactly the right bits. Back-to-back requests and idle gaps separate a one-cycle pulse and held outputs from a stretched or early result.

// File: rtl/vas_pkg.sv
package vas_pkg;

    localparam int VA_W   = 64;
    localparam int CODE_W = 2;
    localparam int PERM_W = 2;

    typedef enum logic [CODE_W-1:0] {
        RES_TLB    = 2'b00,
        RES_DIRECT = 2'b01,
        RES_BAD    = 2'b10
    } vas_res_e;

    typedef enum logic [3:0] {
        SEG_UBAD,
        SEG_ULOW,
        SEG_XUSER,
        SEG_XSUP,
        SEG_XKPHYS,
        SEG_XKMAP,
        SEG_KUNM0,
        SEG_KUNM1,
        SEG_KMAP
    } vas_seg_e;

    localparam logic [PERM_W-1:0] PERM_NONE = 2'b00;
    localparam logic [PERM_W-1:0] PERM_RW   = 2'b11;

    // exclusive upper ends of the ordered ranges (strict less-than)
    localparam logic [VA_W-1:0] ULOW_MAX   = 64'h0000_0000_7FFF_FFFF; // inclusive
    localparam logic [VA_W-1:0] XUSER_END  = 64'h3FFF_FFFF_FFFF_FFFF;
    localparam logic [VA_W-1:0] XSUP_END   = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [VA_W-1:0] XKPHYS_END = 64'hBFFF_FFFF_FFFF_FFFF;
    localparam logic [VA_W-1:0] XKMAP_END  = 64'hFFFF_FFFF_7FFF_FFFF;
    localparam logic [VA_W-1:0] KUNM0_END  = 64'hFFFF_FFFF_A000_0000;
    localparam logic [VA_W-1:0] KUNM1_END  = 64'hFFFF_FFFF_C000_0000;
    localparam logic [VA_W-1:0] USER_MAX   = 64'h3FFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic              vld;
        vas_res_e          code;
        logic [VA_W-1:0]   pa;
        logic [PERM_W-1:0] perm;
    } vas_rsp_t;

endpackage

// File: rtl/vas_region_sel.sv
module vas_region_sel
    import vas_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            user,
    output vas_seg_e        seg
);
    always_comb begin
        if (user && (va > USER_MAX)) begin
            seg = SEG_UBAD;
        end else if (va <= ULOW_MAX) begin
            seg = SEG_ULOW;
        end else if (va < XUSER_END) begin
            seg = SEG_XUSER;
        end else if (va < XSUP_END) begin
            seg = SEG_XSUP;
        end else if (va < XKPHYS_END) begin
            seg = SEG_XKPHYS;
        end else if (va < XKMAP_END) begin
            seg = SEG_XKMAP;
        end else if (va < KUNM0_END) begin
            seg = SEG_KUNM0;
        end else if (va < KUNM1_END) begin
            seg = SEG_KUNM1;
        end else begin
            seg = SEG_KMAP;
        end
    end
endmodule

// File: rtl/vas_region_resolve.sv
module vas_region_resolve
    import vas_pkg::*;
#(
    parameter int SEG_BITS  = 40,
    parameter int PHYS_BITS = 36
) (
    input  vas_seg_e          seg,
    input  logic [VA_W-1:0]   va,
    input  logic              user,
    input  logic              ux,
    input  logic              sx,
    input  logic              kx,
    input  logic              erl,
    output vas_res_e          code,
    output logic [VA_W-1:0]   pa,
    output logic [PERM_W-1:0] perm
);
    localparam logic [VA_W-1:0] SEG_MASK  = {{(VA_W-SEG_BITS){1'b0}}, {SEG_BITS{1'b1}}};
    localparam logic [VA_W-1:0] PHYS_LIM  = {{(VA_W-PHYS_BITS){1'b0}}, {PHYS_BITS{1'b1}}};
    localparam logic [VA_W-1:0] XUSER_LIM = SEG_MASK;
    localparam logic [VA_W-1:0] XSUP_LIM  = 64'h4000_0000_0000_0000 | SEG_MASK;
    localparam logic [VA_W-1:0] XKMAP_LIM = (64'hC000_0000_0000_0000 | SEG_MASK) - 64'h8000_0000;
    localparam logic [VA_W-1:0] XKPHYS_OFF = 64'h03FF_FFFF_FFFF_FFFF;
    localparam logic [VA_W-1:0] LOW32_MASK = 64'h0000_0000_FFFF_FFFF;

    logic     xuser_ok, xsup_ok, xkphys_ok, xkmap_ok;
    vas_res_e code_w;
    logic [VA_W-1:0] pa_w;

    assign xuser_ok  = ux && (va < XUSER_LIM);
    assign xsup_ok   = sx && (va < XSUP_LIM);
    assign xkphys_ok = kx && ((va & XKPHYS_OFF) < PHYS_LIM);
    assign xkmap_ok  = kx && (va < XKMAP_LIM);

    always_comb begin
        code_w = RES_BAD;
        pa_w   = '0;
        unique case (seg)
            SEG_UBAD:   code_w = RES_BAD;
            SEG_ULOW: begin
                if (erl && user) begin
                    code_w = RES_DIRECT;
                    pa_w   = va;
                end else begin
                    code_w = RES_TLB;
                end
            end
            SEG_XUSER:  code_w = xuser_ok ? RES_TLB : RES_BAD;
            SEG_XSUP:   code_w = xsup_ok  ? RES_TLB : RES_BAD;
            SEG_XKPHYS: begin
                if (xkphys_ok) begin
                    code_w = RES_DIRECT;
                    pa_w   = va & SEG_MASK;
                end
            end
            SEG_XKMAP:  code_w = xkmap_ok ? RES_TLB : RES_BAD;
            SEG_KUNM0, SEG_KUNM1: begin
                code_w = RES_DIRECT;
                pa_w   = va & LOW32_MASK;
            end
            SEG_KMAP:   code_w = RES_TLB;
            default:    code_w = RES_BAD;
        endcase
    end

    assign code = code_w;
    assign pa   = pa_w;
    assign perm = (code_w == RES_DIRECT) ? PERM_RW : PERM_NONE;
endmodule

// File: rtl/vas_classify.sv
module vas_classify
    import vas_pkg::*;
#(
    parameter int SEG_BITS  = 40,
    parameter int PHYS_BITS = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_user,
    input  logic              st_ux,
    input  logic              st_sx,
    input  logic              st_kx,
    input  logic              st_erl,
    output logic              rsp_vld,
    output logic [CODE_W-1:0] rsp_code,
    output logic [VA_W-1:0]   rsp_pa,
    output logic [PERM_W-1:0] rsp_perm
);
    vas_seg_e          seg_w;
    vas_res_e          code_w;
    logic [VA_W-1:0]   pa_w;
    logic [PERM_W-1:0] perm_w;
    vas_rsp_t          rsp_d, rsp_q;

    vas_region_sel u_sel (
        .va   (req_va),
        .user (req_user),
        .seg  (seg_w)
    );

    vas_region_resolve #(
        .SEG_BITS  (SEG_BITS),
        .PHYS_BITS (PHYS_BITS)
    ) u_res (
        .seg  (seg_w),
        .va   (req_va),
        .user (req_user),
        .ux   (st_ux),
        .sx   (st_sx),
        .kx   (st_kx),
        .erl  (st_erl),
        .code (code_w),
        .pa   (pa_w),
        .perm (perm_w)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_vld;
        if (req_vld) begin
            rsp_d.code = code_w;
            rsp_d.pa   = pa_w;
            rsp_d.perm = perm_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{vld: 1'b0, code: RES_TLB, pa: '0, perm: PERM_NONE};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld  = rsp_q.vld;
    assign rsp_code = rsp_q.code;
    assign rsp_pa   = rsp_q.pa;
    assign rsp_perm = rsp_q.perm;
endmodule

// File: rtl/vas_classify_chk.sv
module vas_classify_chk
    import vas_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [VA_W-1:0]   req_va,
    input logic              req_user,
    input logic              st_ux,
    input logic              st_erl,
    input logic              rsp_vld,
    input logic [CODE_W-1:0] rsp_code,
    input logic [VA_W-1:0]   rsp_pa,
    input logic [PERM_W-1:0] rsp_perm
);
    assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    assert_no_vld_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> ($stable(rsp_code) && $stable(rsp_pa) && $stable(rsp_perm)));

    assert_user_high_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_user && (req_va > 64'h3FFF_FFFF_FFFF_FFFF)) |=> (rsp_code == RES_BAD));

    assert_low_user_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (req_va <= 64'h7FFF_FFFF) && !(st_erl && req_user)) |=> (rsp_code == RES_TLB));

    assert_xuser_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_user && !st_ux && (req_va > 64'h7FFF_FFFF)
         && (req_va < 64'h3FFF_FFFF_FFFF_FFFF)) |=> (rsp_code == RES_BAD));

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code != 2'b11);

    assert_nondirect_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != RES_DIRECT) |-> ((rsp_pa == '0) && (rsp_perm == 2'b00)));

    assert_direct_rw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == RES_DIRECT) |-> (rsp_perm == 2'b11));
endmodule

bind vas_classify vas_classify_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_va   (req_va),
    .req_user (req_user),
    .st_ux    (st_ux),
    .st_erl   (st_erl),
    .rsp_vld  (rsp_vld),
    .rsp_code (rsp_code),
    .rsp_pa   (rsp_pa),
    .rsp_perm (rsp_perm)
);

// File: tb/sim_vas_classify.sv
module sim_vas_classify;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [1:0] C_TLB = 2'b00, C_DIR = 2'b01, C_BAD = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] req_va = '0;
    logic        req_user = 1'b0, st_ux = 1'b0, st_sx = 1'b0, st_kx = 1'b0, st_erl = 1'b0;
    logic        rsp_vld;
    logic [1:0]  rsp_code;
    logic [63:0] rsp_pa;
    logic [1:0]  rsp_perm;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vas_classify u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
        .req_user(req_user), .st_ux(st_ux), .st_sx(st_sx), .st_kx(st_kx),
        .st_erl(st_erl), .rsp_vld(rsp_vld), .rsp_code(rsp_code),
        .rsp_pa(rsp_pa), .rsp_perm(rsp_perm)
    );

    task automatic check_rsp(input string tag, input logic [1:0] code, input logic [63:0] pa);
        logic [1:0] perm;
        perm = (code == C_DIR) ? 2'b11 : 2'b00;
        total++;
        if (rsp_vld !== 1'b1 || rsp_code !== code || rsp_pa !== pa || rsp_perm !== perm) begin
            bad++;
            $display("FAIL %s: got vld=%b code=%b pa=%h perm=%b, expected vld=1 code=%b pa=%h perm=%b",
                     tag, rsp_vld, rsp_code, rsp_pa, rsp_perm, code, pa, perm);
        end
    endtask

    task automatic set_flags(input logic [4:0] f);
        {req_user, st_ux, st_sx, st_kx, st_erl} = f;
    endtask

    // drive one request, then sample at the next falling edge
    task automatic send(input logic [63:0] va, input logic [4:0] f);
        @(negedge clk);
        req_va  = va;
        set_flags(f);
        req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    // flags order: {user, ux, sx, kx, erl}
    task automatic one(input string tag, input logic [63:0] va, input logic [4:0] f,
                       input logic [1:0] code, input logic [63:0] pa);
        send(va, f);
        check_rsp(tag, code, pa);
    endtask

    // reference written from the requirement text, range by range
    function automatic void model(input logic [63:0] va, input logic [4:0] f,
                                  output logic [1:0] code, output logic [63:0] pa,
                                  output string tag);
        logic u, ux, sx, kx, erl;
        {u, ux, sx, kx, erl} = f;
        pa = '0;
        if (u && va >= 64'h4000_0000_0000_0000) begin
            tag = "R3"; code = C_BAD;
        end else if (va < 64'h8000_0000) begin
            tag = "R4";
            if (u && erl) begin code = C_DIR; pa = va; end else code = C_TLB;
        end else if (va <= 64'h3FFF_FFFF_FFFF_FFFE) begin
            tag = "R5"; code = (ux && va <= 64'h0000_00FF_FFFF_FFFE) ? C_TLB : C_BAD;
        end else if (va <= 64'h7FFF_FFFF_FFFF_FFFE) begin
            tag = "R6"; code = (sx && va <= 64'h4000_00FF_FFFF_FFFE) ? C_TLB : C_BAD;
        end else if (va <= 64'hBFFF_FFFF_FFFF_FFFE) begin
            tag = "R7";
            if (kx && {6'b0, va[57:0]} <= 64'h0000_000F_FFFF_FFFE) begin
                code = C_DIR; pa = {24'b0, va[39:0]};
            end else code = C_BAD;
        end else if (va <= 64'hFFFF_FFFF_7FFF_FFFE) begin
            tag = "R8"; code = (kx && va <= 64'hC000_00FF_7FFF_FFFE) ? C_TLB : C_BAD;
        end else if (va <= 64'hFFFF_FFFF_BFFF_FFFF) begin
            tag = "R9"; code = C_DIR; pa = {32'b0, va[31:0]};
        end else begin
            tag = "R9"; code = C_TLB;
        end
    endfunction

    task automatic t_reset_R1();
        total++;
        if (rsp_vld !== 1'b0 || rsp_code !== 2'b00 || rsp_pa !== 64'd0 || rsp_perm !== 2'b00) begin
            bad++;
            $display("FAIL R1 reset: got vld=%b code=%b pa=%h perm=%b, expected all zero",
                     rsp_vld, rsp_code, rsp_pa, rsp_perm);
        end
    endtask

    task automatic t_user_R3_R4();
        one("R3 user xsup",   64'h4000_0000_0000_0000, 5'b11111, C_BAD, 64'd0);
        one("R3 user kseg",   64'hFFFF_FFFF_8000_0000, 5'b11111, C_BAD, 64'd0);
        one("R4 user erl",    64'h0000_0000_0000_1000, 5'b10001, C_DIR, 64'h1000);
        one("R4 user no erl", 64'h0000_0000_0000_1000, 5'b10000, C_TLB, 64'd0);
        one("R4 kern erl",    64'h0000_0000_7FFF_FFFF, 5'b00001, C_TLB, 64'd0);
        one("R4 user edge",   64'h0000_0000_7FFF_FFFF, 5'b10001, C_DIR, 64'h7FFF_FFFF);
    endtask

    task automatic t_xuser_R5();
        one("R5 in",       64'h0000_00FF_FFFF_FFFE, 5'b01000, C_TLB, 64'd0);
        one("R5 limit",    64'h0000_00FF_FFFF_FFFF, 5'b01000, C_BAD, 64'd0);
        one("R5 disabled", 64'h0000_0000_8000_0000, 5'b00111, C_BAD, 64'd0);
        one("R5 user ok",  64'h0000_0000_8000_0000, 5'b11000, C_TLB, 64'd0);
    endtask

    task automatic t_xsup_R6();
        one("R6 in",       64'h4000_00FF_FFFF_FFFE, 5'b00100, C_TLB, 64'd0);
        one("R6 limit",    64'h4000_00FF_FFFF_FFFF, 5'b00100, C_BAD, 64'd0);
        one("R6 disabled", 64'h4000_0000_0000_0000, 5'b01011, C_BAD, 64'd0);
        one("R6 low edge", 64'h3FFF_FFFF_FFFF_FFFF, 5'b00100, C_TLB, 64'd0);
    endtask

    task automatic t_xkphys_R7();
        one("R7 attr bits", 64'h9000_0001_2345_6789, 5'b00010, C_DIR, 64'h0000_0001_2345_6789);
        one("R7 in edge",   64'h8000_000F_FFFF_FFFE, 5'b00010, C_DIR, 64'h0000_000F_FFFF_FFFE);
        one("R7 limit",     64'h8000_000F_FFFF_FFFF, 5'b00010, C_BAD, 64'd0);
        one("R7 mask top",  64'hBC00_0000_0000_0010, 5'b00010, C_DIR, 64'h10);
        one("R7 disabled",  64'h8000_0000_0000_0000, 5'b01101, C_BAD, 64'd0);
        one("R7 low edge",  64'h7FFF_FFFF_FFFF_FFFF, 5'b00010, C_BAD, 64'd0);
    endtask

    task automatic t_xkmap_R8();
        one("R8 in",       64'hC000_00FF_7FFF_FFFE, 5'b00010, C_TLB, 64'd0);
        one("R8 limit",    64'hC000_00FF_7FFF_FFFF, 5'b00010, C_BAD, 64'd0);
        one("R8 top",      64'hFFFF_FFFF_7FFF_FFFE, 5'b00010, C_BAD, 64'd0);
        one("R8 disabled", 64'hC000_0000_0000_0000, 5'b01101, C_BAD, 64'd0);
    endtask

    task automatic t_compat_R9();
        one("R9 seam",   64'hFFFF_FFFF_7FFF_FFFF, 5'b00000, C_DIR, 64'h7FFF_FFFF);
        one("R9 unm0",   64'hFFFF_FFFF_8000_1234, 5'b00000, C_DIR, 64'h8000_1234);
        one("R9 unm1",   64'hFFFF_FFFF_A000_0000, 5'b00010, C_DIR, 64'hA000_0000);
        one("R9 unm1 e", 64'hFFFF_FFFF_BFFF_FFFF, 5'b01111, C_DIR, 64'hBFFF_FFFF);
        one("R9 mapped", 64'hFFFF_FFFF_C000_0000, 5'b00000, C_TLB, 64'd0);
        one("R9 top",    64'hFFFF_FFFF_FFFF_FFFF, 5'b01111, C_TLB, 64'd0);
    endtask

    task automatic t_timing_R2();
        logic [63:0] held;
        // back-to-back pair
        @(negedge clk);
        set_flags(5'b00010);
        req_va = 64'h8000_0000_0000_0040; req_vld = 1'b1;
        @(negedge clk);
        check_rsp("R2 b2b first", C_DIR, 64'h40);
        req_va = 64'hFFFF_FFFF_FFFF_0000;
        @(negedge clk);
        check_rsp("R2 b2b second", C_TLB, 64'd0);
        req_va = 64'hFFFF_FFFF_9000_0008;
        @(negedge clk);
        req_vld = 1'b0;
        check_rsp("R2 b2b third", C_DIR, 64'h9000_0008);
        held = 64'h9000_0008;
        // idle: change inputs, outputs must hold and vld stays low
        req_va = 64'h4000_0000_0000_0000;
        set_flags(5'b11111);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            total++;
            if (rsp_vld !== 1'b0 || rsp_code !== C_DIR || rsp_pa !== held || rsp_perm !== 2'b11) begin
                bad++;
                $display("FAIL R2 idle hold: got vld=%b code=%b pa=%h perm=%b, expected vld=0 code=01 pa=%h perm=11",
                         rsp_vld, rsp_code, rsp_pa, rsp_perm, held);
            end
        end
    endtask

    task automatic t_sweep();
        logic [63:0] pts [31];
        logic [1:0]  ec;
        logic [63:0] ep;
        string       tg;
        pts = '{64'h0, 64'h7FFF_FFFF, 64'h8000_0000, 64'hFF_FFFF_FFFE, 64'hFF_FFFF_FFFF,
                64'h100_0000_0000, 64'h3FFF_FFFF_FFFF_FFFE, 64'h3FFF_FFFF_FFFF_FFFF,
                64'h4000_0000_0000_0000, 64'h4000_00FF_FFFF_FFFE, 64'h4000_00FF_FFFF_FFFF,
                64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                64'h8000_000F_FFFF_FFFE, 64'h8000_000F_FFFF_FFFF, 64'h9800_0001_2345_6788,
                64'hBC00_0000_0000_0010, 64'hBFFF_FFFF_FFFF_FFFE, 64'hBFFF_FFFF_FFFF_FFFF,
                64'hC000_0000_0000_0000, 64'hC000_00FF_7FFF_FFFE, 64'hC000_00FF_7FFF_FFFF,
                64'hFFFF_FFFF_7FFF_FFFE, 64'hFFFF_FFFF_7FFF_FFFF, 64'hFFFF_FFFF_8000_0000,
                64'hFFFF_FFFF_9FFF_FFFF, 64'hFFFF_FFFF_A000_0000, 64'hFFFF_FFFF_BFFF_FFFF,
                64'hFFFF_FFFF_C000_0000, 64'hFFFF_FFFF_FFFF_FFFF};
        for (int f = 0; f < 32; f++) begin
            for (int p = 0; p < 31; p++) begin
                model(pts[p], 5'(f), ec, ep, tg);
                send(pts[p], 5'(f));
                check_rsp($sformatf("%s sweep va=%h flags=%b", tg, pts[p], 5'(f)), ec, ep);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got no end of run, expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_user_R3_R4();
        t_xuser_R5();
        t_xsup_R6();
        t_xkphys_R7();
        t_xkmap_R8();
        t_compat_R9();
        t_timing_R2();
        t_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule